// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master-clock cycles fit into one period of the audio frame clock, which runs at the sample rate. It decides which supported oversampling ratio the system is using. The accepted ratios are 128, 192, 256, 384, 512 and 768 master clocks per frame. A measured period within eight cycles of one of them counts as that ratio. Any other period makes the block ask the converter path to shut down and mute.

The frame clock is asynchronous to the master clock. It passes through a two-flop synchronizer, and each rising edge seen in the master-clock domain ends one measurement and starts the next. A result only releases mute after two periods in a row agree on the same ratio. One bad period re-asserts mute at once. A separate counter detects a frame clock that has stopped.

A small monitor clocked by the frame clock detects the opposite fault: a master clock that has stopped while frames continue. It reports this as a power-down condition.

Top module: `mclk_ratio_detector`

## Requirements
- R1: While reset is held and right after it: ratio_code = 0, ratio_invalid = 1, locked = 0, mute_req = 1, frame_lost = 0, mclk_stopped = 0.
- R2: A measured period within ±8 master clocks of 128, 192, 256, 384, 512 or 768 gives ratio_code 0, 1, 2, 3, 4 or 5 respectively (ascending ratio order) and ratio_invalid = 0.
- R3: A measured period 9 or more cycles away from every supported ratio sets ratio_invalid = 1, locked = 0 and mute_req = 1.
- R4: locked rises only after two consecutive measured periods classify to the same code. mute_req is always the inverse of locked.
- R5: A single out-of-window period clears locked and raises mute_req at the frame edge that ends it. Two new matching periods are then needed to lock again.
- R6: A change from one valid ratio to a different valid ratio updates ratio_code and drops locked for one period before it relocks.
- R7: If more than 1025 master clocks pass without a detected frame rising edge, frame_lost = 1, locked = 0, mute_req = 1 and ratio_invalid = 1. A period of exactly 1025 never raises frame_lost. The next frame edge clears frame_lost.
- R8: If the master clock stops while the frame clock keeps running, mclk_stopped rises within ten frame periods. It stays low during the first frame after the stop. It falls again within six frames after the master clock resumes.
- R9: The first frame edge after reset or after a frame loss only starts a measurement. ratio_invalid stays 1 until the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, measurement domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame (sample-rate) clock, asynchronous |
| ratio_code | output | 3 | Last valid ratio code, 0..5 ascending |
| ratio_invalid | output | 1 | Last measurement matched no ratio |
| locked | output | 1 | Ratio confirmed on two consecutive periods |
| mute_req | output | 1 | Request to shut down and mute the converter path |
| frame_lost | output | 1 | Frame clock absent for over 1025 master clocks |
| mclk_stopped | output | 1 | Master clock stopped while frames continue (frame domain) |

## Verification
The frame-edge measurement and the saturation of the period counter can land on the same master-clock edge. This happens when a frame period equals the counter's saturation value. The bench provokes it with a run of 1025-cycle frames and counts every rising edge of frame_lost: there must be none. Frames of 1026 cycles must then raise it, because the edge loses the race by one cycle. The bench also sweeps every ratio at offsets of -9, -8, 0, +8 and +9 cycles and computes the expected code from the ratio table, so the edges of the tolerance window are checked from both sides.

// File: rtl/mcrd_pkg.sv
package mcrd_pkg;
  localparam int unsigned NUM_RATIOS = 6;
  localparam int unsigned CODE_W     = $clog2(NUM_RATIOS);

  // Ratios alternate 128*2^k and 192*2^k in ascending order.
  function automatic int unsigned ratio_of(input int unsigned idx);
    int unsigned base;
    base = ((idx % 2) == 1) ? 192 : 128;
    return base << (idx / 2);
  endfunction
endpackage

// File: rtl/mcrd_sync.sv
module mcrd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mcrd_classifier.sv
module mcrd_classifier
  import mcrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 8
) (
  input  logic [CNT_W-1:0]  period,
  output logic              match_valid,
  output logic [CODE_W-1:0] match_code
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_win
    localparam int unsigned CENTER = ratio_of(gi);
    localparam int unsigned LO     = CENTER - TOL;
    localparam int unsigned HI     = CENTER + TOL;
    assign hit[gi] = (32'(period) >= LO) && (32'(period) <= HI);
  end

  always_comb begin
    match_code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) match_code = CODE_W'(i);
    end
    match_valid = |hit;
  end
endmodule

// File: rtl/mcrd_lock_ctrl.sv
module mcrd_lock_ctrl
  import mcrd_pkg::*;
#(
  parameter int LOSS_LIMIT = 1024,
  parameter int CNT_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_sync,
  input  logic              cls_valid,
  input  logic [CODE_W-1:0] cls_code,
  output logic [CNT_W-1:0]  period,
  output logic [CODE_W-1:0] ratio_code,
  output logic              ratio_invalid,
  output logic              locked,
  output logic              frame_lost,
  output logic              act_tog
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_LIMIT + 1);

  logic              fc_dly_q, fc_dly_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              started_q, started_d;
  logic              prev_ok_q, prev_ok_d;
  logic [CODE_W-1:0] prev_code_q, prev_code_d;
  logic              locked_q, locked_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              inval_q, inval_d;
  logic              lost_q, lost_d;
  logic              tog_q, tog_d;

  logic rise, sat, measure, loss_evt;

  always_comb begin
    rise     = fc_sync & ~fc_dly_q;
    sat      = (cnt_q == CNT_MAX);
    measure  = rise & started_q;
    loss_evt = sat & ~rise;

    fc_dly_d    = fc_sync;
    cnt_d       = cnt_q;
    started_d   = started_q;
    prev_ok_d   = prev_ok_q;
    prev_code_d = prev_code_q;
    locked_d    = locked_q;
    code_d      = code_q;
    inval_d     = inval_q;
    lost_d      = lost_q;
    tog_d       = tog_q;

    if (rise) begin
      cnt_d     = CNT_W'(1);
      started_d = 1'b1;
      lost_d    = 1'b0;
      tog_d     = ~tog_q;
    end else if (!sat) begin
      cnt_d = cnt_q + CNT_W'(1);
    end

    if (measure) begin
      locked_d  = cls_valid & prev_ok_q & (cls_code == prev_code_q);
      prev_ok_d = cls_valid;
      inval_d   = ~cls_valid;
      if (cls_valid) begin
        prev_code_d = cls_code;
        code_d      = cls_code;
      end
    end

    if (loss_evt) begin
      started_d = 1'b0;
      prev_ok_d = 1'b0;
      locked_d  = 1'b0;
      inval_d   = 1'b1;
      lost_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_dly_q    <= 1'b0;
      cnt_q       <= '0;
      started_q   <= 1'b0;
      prev_ok_q   <= 1'b0;
      prev_code_q <= '0;
      locked_q    <= 1'b0;
      code_q      <= '0;
      inval_q     <= 1'b1;
      lost_q      <= 1'b0;
      tog_q       <= 1'b0;
    end else begin
      fc_dly_q    <= fc_dly_d;
      cnt_q       <= cnt_d;
      started_q   <= started_d;
      prev_ok_q   <= prev_ok_d;
      prev_code_q <= prev_code_d;
      locked_q    <= locked_d;
      code_q      <= code_d;
      inval_q     <= inval_d;
      lost_q      <= lost_d;
      tog_q       <= tog_d;
    end
  end

  assign period        = cnt_q;
  assign ratio_code    = code_q;
  assign ratio_invalid = inval_q;
  assign locked        = locked_q;
  assign frame_lost    = lost_q;
  assign act_tog       = tog_q;

  // R4: lock can only appear at a frame edge that follows an accepted period
  a_r4_lock_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(rise) && $past(prev_ok_q));

  // R2: a locked ratio is never flagged invalid
  a_r2_locked_valid: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !inval_q);

  // R7: frame loss and lock exclude each other
  a_r7_lost_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |-> !locked_q);

  // R7: the period counter stays within its saturation value
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R5: a rejected measurement leaves the block unlocked
  a_r5_bad_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (measure && !cls_valid) |=> !locked_q);
endmodule

// File: rtl/mcrd_stop_mon.sv
module mcrd_stop_mon #(
  parameter int STOP_FRAMES = 4
) (
  input  logic fclk,
  input  logic arst_n,
  input  logic tog_async,
  output logic mclk_stopped
);
  localparam int IDLE_W = $clog2(STOP_FRAMES + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(STOP_FRAMES);

  logic frst_n;
  logic tog_s;
  logic tog_dly_q, tog_dly_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic stop_q, stop_d;
  logic changed;

  mcrd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(fclk), .arst_n(arst_n), .d(1'b1), .q(frst_n));

  mcrd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_tog_sync (
    .clk(fclk), .arst_n(frst_n), .d(tog_async), .q(tog_s));

  always_comb begin
    changed   = tog_s ^ tog_dly_q;
    tog_dly_d = tog_s;
    if (changed)                idle_d = '0;
    else if (idle_q == IDLE_MAX) idle_d = idle_q;
    else                        idle_d = idle_q + IDLE_W'(1);
    stop_d = (idle_d == IDLE_MAX);
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      tog_dly_q <= 1'b0;
      idle_q    <= '0;
      stop_q    <= 1'b0;
    end else begin
      tog_dly_q <= tog_dly_d;
      idle_q    <= idle_d;
      stop_q    <= stop_d;
    end
  end

  assign mclk_stopped = stop_q;

  // R8: power-down flag rises only after a frame with no master activity
  a_r8_stop_after_idle: assert property (@(posedge fclk) disable iff (!frst_n)
    $rose(stop_q) |-> $past(!changed));

  // R8: the idle counter saturates at its limit
  a_r8_idle_bound: assert property (@(posedge fclk) disable iff (!frst_n)
    idle_q <= IDLE_MAX);
endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector
  import mcrd_pkg::*;
#(
  parameter int LOSS_LIMIT  = 1024,
  parameter int TOL         = 8,
  parameter int STOP_FRAMES = 4
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              frame_clk,
  output logic [CODE_W-1:0] ratio_code,
  output logic              ratio_invalid,
  output logic              locked,
  output logic              mute_req,
  output logic              frame_lost,
  output logic              mclk_stopped
);
  localparam int CNT_W = $clog2(LOSS_LIMIT + 2);

  logic              mrst_n;
  logic              fc_sync;
  logic [CNT_W-1:0]  period;
  logic              cls_valid;
  logic [CODE_W-1:0] cls_code;
  logic              act_tog;

  mcrd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_mrst_sync (
    .clk(mclk), .arst_n(rst_n), .d(1'b1), .q(mrst_n));

  mcrd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_fc_sync (
    .clk(mclk), .arst_n(mrst_n), .d(frame_clk), .q(fc_sync));

  mcrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .period(period), .match_valid(cls_valid), .match_code(cls_code));

  mcrd_lock_ctrl #(.LOSS_LIMIT(LOSS_LIMIT), .CNT_W(CNT_W)) u_lock (
    .clk(mclk), .rst_n(mrst_n), .fc_sync(fc_sync),
    .cls_valid(cls_valid), .cls_code(cls_code),
    .period(period), .ratio_code(ratio_code),
    .ratio_invalid(ratio_invalid), .locked(locked),
    .frame_lost(frame_lost), .act_tog(act_tog));

  mcrd_stop_mon #(.STOP_FRAMES(STOP_FRAMES)) u_stop (
    .fclk(frame_clk), .arst_n(rst_n), .tog_async(act_tog),
    .mclk_stopped(mclk_stopped));

  assign mute_req = ~locked;
endmodule

// File: tb/mclk_ratio_detector_tb.sv
module mclk_ratio_detector_tb;
  logic       clk_base = 1'b0;
  logic       mclk_en  = 1'b1;
  logic       mclk;
  logic       rst_n;
  logic       fc;
  logic [2:0] ratio_code;
  logic       ratio_invalid, locked, mute_req, frame_lost, mclk_stopped;

  int n_chk = 0;
  int n_bad = 0;
  int lost_evt = 0;
  bit done = 0;

  always #10 clk_base = ~clk_base;
  assign mclk = clk_base & mclk_en;

  mclk_ratio_detector u_dut (
    .mclk(mclk), .rst_n(rst_n), .frame_clk(fc),
    .ratio_code(ratio_code), .ratio_invalid(ratio_invalid),
    .locked(locked), .mute_req(mute_req),
    .frame_lost(frame_lost), .mclk_stopped(mclk_stopped));

  always @(posedge frame_lost) lost_evt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frames(input int n, input int per);
    for (int f = 0; f < n; f++) begin
      fc = 1'b1;
      repeat (per / 2) @(negedge clk_base);
      fc = 1'b0;
      repeat (per - per / 2) @(negedge clk_base);
    end
  endtask

  task automatic hold(input int cyc);
    repeat (cyc) @(negedge clk_base);
  endtask

  int ratios[6] = '{128, 192, 256, 384, 512, 768};
  int offs[5]   = '{-9, -8, 0, 8, 9};

  initial begin
    int base_evt;
    rst_n = 1'b0;
    fc    = 1'b0;
    hold(5);
    chk("R1 code", ratio_code, 0);
    chk("R1 invalid", ratio_invalid, 1);
    chk("R1 locked", locked, 0);
    chk("R1 mute", mute_req, 1);
    chk("R1 lost", frame_lost, 0);
    chk("R1 stopped", mclk_stopped, 0);
    rst_n = 1'b1;
    hold(5);

    // R9 / R4 start-up sequence
    frames(1, 256);
    chk("R9 first edge only starts", ratio_invalid, 1);
    frames(1, 256);
    chk("R9 second edge measures", ratio_invalid, 0);
    chk("R2 code 256", ratio_code, 2);
    chk("R4 one period not locked", locked, 0);
    frames(1, 256);
    chk("R4 two periods locked", locked, 1);
    chk("R4 mute released", mute_req, 0);

    // R2 / R3 sweep over every ratio and window edge
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 5; j++) begin
        int per;
        bit ok;
        per = ratios[k] + offs[j];
        ok  = (offs[j] >= -8) && (offs[j] <= 8);
        frames(3, 100);
        frames(2, per);
        chk("R4 single match no lock", locked, 0);
        frames(1, per);
        if (ok) begin
          chk("R2 code", ratio_code, k);
          chk("R2 valid", ratio_invalid, 0);
          chk("R4 locked", locked, 1);
          chk("R4 mute", mute_req, 0);
        end else begin
          chk("R3 invalid", ratio_invalid, 1);
          chk("R3 unlocked", locked, 0);
          chk("R3 mute", mute_req, 1);
        end
      end
    end

    // R6 valid-to-valid change
    frames(3, 384);
    chk("R6 locked at 384", locked, 1);
    frames(1, 512);
    chk("R6 still locked", locked, 1);
    frames(1, 512);
    chk("R6 code follows", ratio_code, 4);
    chk("R6 lock dropped", locked, 0);
    frames(1, 512);
    chk("R6 relocked", locked, 1);

    // R5 single bad period
    frames(1, 540);
    chk("R5 before bad edge", locked, 1);
    frames(1, 512);
    chk("R5 unlock", locked, 0);
    chk("R5 mute", mute_req, 1);
    chk("R5 invalid", ratio_invalid, 1);
    frames(1, 512);
    chk("R5 one good no lock", locked, 0);
    frames(1, 512);
    chk("R5 relock", locked, 1);

    // R7 frame loss (last rise began a 512 frame)
    hold(400);
    chk("R7 not yet lost", frame_lost, 0);
    chk("R7 still locked", locked, 1);
    hold(300);
    chk("R7 lost", frame_lost, 1);
    chk("R7 unlock", locked, 0);
    chk("R7 mute", mute_req, 1);
    chk("R7 invalid", ratio_invalid, 1);
    frames(1, 256);
    chk("R7 edge clears lost", frame_lost, 0);
    chk("R9 restart after loss", ratio_invalid, 1);
    frames(1, 256);
    chk("R9 measures after loss", ratio_invalid, 0);
    frames(1, 256);
    chk("R7 relock after loss", locked, 1);

    // R7 boundary: edge and saturation on the same cycle
    base_evt = lost_evt;
    frames(4, 1025);
    chk("R7 period 1025 no loss", lost_evt - base_evt, 0);
    frames(2, 1026);
    chk("R7 period 1026 loss", (lost_evt - base_evt) > 0, 1);

    // R8 master clock stop
    frames(3, 256);
    mclk_en = 1'b0;
    frames(1, 256);
    chk("R8 not yet stopped", mclk_stopped, 0);
    frames(10, 256);
    chk("R8 stopped", mclk_stopped, 1);
    mclk_en = 1'b1;
    frames(6, 256);
    chk("R8 resumed", mclk_stopped, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_base);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule